// File: doc/BRIEF.md
# Direct-Mapped PCI Configuration Translator

This block lets a big-endian processor reach PCI configuration space through a flat 4 MiB memory window instead of an address/data register pair. A processor access names the target device by setting one select bit in the upper part of the window offset. The function and register bits sit in the low part. The block decodes the window and turns the lowest set select bit into a binary device number. It then issues one configuration request carrying the translated address, the access size, the direction and the write data.

Both the processor side and the configuration request side use valid/ready. A request is taken when valid and ready are both high at a clock edge. Once a side raises valid, it holds valid and its payload steady until that edge. Read results come back on a response strobe with no back-pressure. The configuration side returns data with `cfg_rvalid`, and the block passes it to the processor on `cpu_rvalid` in the same cycle. Only one request is ever outstanding. The block keeps `cpu_ready` low until a write is taken on the configuration side or until a read has returned its data. Data on the processor side is big-endian and data on the configuration side is little-endian, so 2-byte and 4-byte data is byte-reversed in both directions. Single bytes pass straight through.

Top module: `cfgx_bridge`

## Requirements
- R1: The block forwards an access only when `cpu_addr[31:22]` equals 10'h202, which is the window from 0x8080_0000 to 0x80BF_FFFF. Any other accepted access produces no configuration request and no read response, and `cpu_ready` is high again in the next cycle.
- R2: `cfg_addr[10:0]` equals `cpu_addr[10:0]` of the accepted access.
- R3: `cfg_addr[14:11]` is the index, from 0 to 10, of the lowest set bit among `cpu_addr[21:11]`. The scan runs from bit 11 upward.
- R4: When none of `cpu_addr[21:11]` is set, `cfg_addr[14:11]` is 11.
- R5: For size code 2, the forwarded write data is `{16'h0, cpu_wdata[7:0], cpu_wdata[15:8]}`, and the returned read data is `{16'h0, cfg_rdata[7:0], cfg_rdata[15:8]}`.
- R6: For size code 4, all four bytes are reversed. Byte k of the output is byte 3-k of the input, for both write data and read data.
- R7: For size code 1, write data is forwarded as `{24'h0, cpu_wdata[7:0]}` and read data is returned as `{24'h0, cfg_rdata[7:0]}`.
- R8: `cfg_size` carries the accepted size code unchanged. Only the codes 1, 2 and 4 are legal. `cfg_write` carries the accepted `cpu_write` unchanged.
- R9: The block holds only one request at a time. `cpu_ready` is low from the cycle after an in-window acceptance until the cycle after the configuration side takes a write, or until the cycle after `cfg_rvalid` returns read data. While `cfg_valid` is high and `cfg_ready` is low, the request and its payload stay unchanged.
- R10: In the first cycle after reset is released, `cpu_ready` is high, and `cfg_valid` and `cpu_rvalid` are low.
- R11: `cfg_valid` rises in the cycle after an in-window acceptance. `cpu_rvalid` equals `cfg_rvalid` in the same cycle only while the block waits for read data. A `cfg_rvalid` seen at any other time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor access valid |
| cpu_ready | output | 1 | Block can accept an access |
| cpu_addr | input | 32 | Processor physical address |
| cpu_size | input | 3 | Access size code: 1, 2 or 4 bytes |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 32 | Write data, big-endian lanes |
| cpu_rvalid | output | 1 | Read data strobe to processor |
| cpu_rdata | output | 32 | Read data, byte order corrected |
| cfg_valid | output | 1 | Configuration request valid |
| cfg_ready | input | 1 | Configuration side takes the request |
| cfg_addr | output | 15 | Device number and function/register bits |
| cfg_size | output | 3 | Forwarded size code |
| cfg_write | output | 1 | Forwarded direction |
| cfg_wdata | output | 32 | Write data, little-endian lanes |
| cfg_rvalid | input | 1 | Configuration read data strobe |
| cfg_rdata | input | 32 | Configuration read data |

## Verification
The assertions check the following on every cycle:
- the request stays stable under back-pressure;
- `cpu_ready` stays low while a request or a read is pending;
- the state right after reset is correct;
- no request follows an access outside the window;
- the device field never exceeds 11;
- the response strobe is tied to `cfg_rvalid`;
- the lanes of a 4-byte read are reversed.

Only the bench scenarios can show the exact device number for a given pattern of select bits, the byte order for each size in each direction, and the dropping of a stray `cfg_rvalid`. For those the bench compares every output against its behavioural model under random stalls on the configuration side.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_WAIT  = 2'd2
  } cfgx_phase_e;

  localparam int SIZE_W = 3;
  localparam logic [SIZE_W-1:0] SZ_BYTE = 3'd1;
  localparam logic [SIZE_W-1:0] SZ_HALF = 3'd2;
  localparam logic [SIZE_W-1:0] SZ_WORD = 3'd4;
endpackage

// File: rtl/cfgx_addr_map.sv
module cfgx_addr_map #(
  parameter int ADDR_W   = 32,
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int WIN_LOG2 = 22,
  parameter int SEL_LO   = 11,
  parameter int SEL_N    = 11,
  parameter int DEV_W    = $clog2(SEL_N + 1),
  parameter int CFG_AW   = SEL_LO + DEV_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [CFG_AW-1:0] cfg_addr
);
  localparam int TAG_W = ADDR_W - WIN_LOG2;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

  logic [SEL_N-1:0] sel_bits;
  logic [DEV_W-1:0] dev_num;
  logic             dev_found;

  assign sel_bits = addr[SEL_LO +: SEL_N];
  assign hit      = (addr[ADDR_W-1:WIN_LOG2] == WIN_TAG);

  // Lowest set select bit wins; no select bit maps to SEL_N.
  always_comb begin
    dev_num   = DEV_W'(SEL_N);
    dev_found = 1'b0;
    for (int i = 0; i < SEL_N; i++) begin
      if (!dev_found && sel_bits[i]) begin
        dev_num   = DEV_W'(i);
        dev_found = 1'b1;
      end
    end
  end

  assign cfg_addr = {dev_num, addr[SEL_LO-1:0]};
endmodule

// File: rtl/cfgx_lane_swap.sv
module cfgx_lane_swap
  import cfgx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SIZE_W-1:0] size,
  output logic [DATA_W-1:0] dout
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] full_rev;

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_rev
      assign full_rev[8*g +: 8] = din[8*(NB-1-g) +: 8];
    end
  endgenerate

  always_comb begin
    case (size)
      SZ_HALF: dout = {{(DATA_W-16){1'b0}}, din[7:0], din[15:8]};
      SZ_WORD: dout = full_rev;
      default: dout = {{(DATA_W-8){1'b0}}, din[7:0]};
    endcase
  end
endmodule

// File: rtl/cfgx_req_ctrl.sv
module cfgx_req_ctrl
  import cfgx_pkg::*;
#(
  parameter int CFG_AW = 15,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_hit,
  input  logic [CFG_AW-1:0] acc_addr,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              acc_write,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              acc_ready,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic [SIZE_W-1:0] cfg_size,
  output logic              cfg_write,
  output logic [DATA_W-1:0] cfg_wdata,
  input  logic              cfg_rvalid,
  output logic              rsp_valid
);
  cfgx_phase_e phase_q, phase_d;
  logic        take;

  assign acc_ready = (phase_q == PH_IDLE);
  assign cfg_valid = (phase_q == PH_ISSUE);
  assign rsp_valid = (phase_q == PH_WAIT) && cfg_rvalid;
  assign take      = acc_valid && acc_ready && acc_hit;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:  if (take) phase_d = PH_ISSUE;
      PH_ISSUE: if (cfg_ready) phase_d = cfg_write ? PH_IDLE : PH_WAIT;
      PH_WAIT:  if (cfg_rvalid) phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  // Payload registers load only on an in-window acceptance.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_addr  <= '0;
      cfg_size  <= SZ_BYTE;
      cfg_write <= 1'b0;
      cfg_wdata <= '0;
    end else if (take) begin
      cfg_addr  <= acc_addr;
      cfg_size  <= acc_size;
      cfg_write <= acc_write;
      cfg_wdata <= acc_wdata;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_addr) && $stable(cfg_size)
      && $stable(cfg_write) && $stable(cfg_wdata));

  assert_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> !acc_ready);

  assert_rdwait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ready && !cfg_write |=> !acc_ready);

  assert_launch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready && acc_hit |=> cfg_valid);

  assert_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> acc_ready && !cfg_valid && !rsp_valid);
endmodule

// File: rtl/cfgx_bridge.sv
module cfgx_bridge
  import cfgx_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int WIN_LOG2 = 22,
  parameter int SEL_LO   = 11,
  parameter int SEL_N    = 11,
  localparam int DEV_W   = $clog2(SEL_N + 1),
  localparam int CFG_AW  = SEL_LO + DEV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [2:0]        cpu_size,
  input  logic              cpu_write,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic [2:0]        cfg_size,
  output logic              cfg_write,
  output logic [DATA_W-1:0] cfg_wdata,
  input  logic              cfg_rvalid,
  input  logic [DATA_W-1:0] cfg_rdata
);
  logic              win_hit;
  logic [CFG_AW-1:0] map_addr;
  logic [DATA_W-1:0] wdata_le;

  cfgx_addr_map #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2),
    .SEL_LO(SEL_LO), .SEL_N(SEL_N), .DEV_W(DEV_W), .CFG_AW(CFG_AW)
  ) u_map (
    .addr(cpu_addr), .hit(win_hit), .cfg_addr(map_addr)
  );

  cfgx_lane_swap #(.DATA_W(DATA_W)) u_wswap (
    .din(cpu_wdata), .size(cpu_size), .dout(wdata_le)
  );

  cfgx_req_ctrl #(.CFG_AW(CFG_AW), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(cpu_valid), .acc_hit(win_hit), .acc_addr(map_addr),
    .acc_size(cpu_size), .acc_write(cpu_write), .acc_wdata(wdata_le),
    .acc_ready(cpu_ready),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_addr(cfg_addr),
    .cfg_size(cfg_size), .cfg_write(cfg_write), .cfg_wdata(cfg_wdata),
    .cfg_rvalid(cfg_rvalid), .rsp_valid(cpu_rvalid)
  );

  // Read data is reordered with the size held for the pending request.
  cfgx_lane_swap #(.DATA_W(DATA_W)) u_rswap (
    .din(cfg_rdata), .size(cfg_size), .dout(cpu_rdata)
  );

  assert_outside_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_ready && (cpu_addr[ADDR_W-1:WIN_LOG2] != WIN_BASE[ADDR_W-1:WIN_LOG2])
      |=> !cfg_valid && cpu_ready);

  assert_devmax_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> cfg_addr[CFG_AW-1:SEL_LO] <= DEV_W'(SEL_N));

  assert_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> cfg_rvalid && !cfg_valid && !cpu_ready);

  assert_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid && cfg_size == SZ_WORD |-> cpu_rdata[7:0] == cfg_rdata[DATA_W-1 -: 8]);
endmodule

// File: tb/sim_cfgx_bridge.sv
`timescale 1ns/1ps
module sim_cfgx_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_ready;
  logic [31:0] cpu_addr = '0;
  logic [2:0]  cpu_size = 3'd1;
  logic        cpu_write = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        cfg_valid;
  logic        cfg_ready = 1'b0;
  logic [14:0] cfg_addr;
  logic [2:0]  cfg_size;
  logic        cfg_write;
  logic [31:0] cfg_wdata;
  logic        cfg_rvalid = 1'b0;
  logic [31:0] cfg_rdata = '0;

  always #2 clk = ~clk;

  cfgx_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
    .cpu_size(cpu_size), .cpu_write(cpu_write), .cpu_wdata(cpu_wdata),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_addr(cfg_addr),
    .cfg_size(cfg_size), .cfg_write(cfg_write), .cfg_wdata(cfg_wdata),
    .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [31:0] ref_order(input logic [31:0] d, input int n);
    logic [31:0] r = '0;
    for (int k = 0; k < n; k++) r[8*k +: 8] = d[8*(n-1-k) +: 8];
    return r;
  endfunction

  function automatic int ref_dev(input logic [31:0] a);
    for (int i = 0; i < 11; i++) if (a[11+i]) return i;
    return 11;
  endfunction

  function automatic bit ref_inwin(input logic [31:0] a);
    return (a >= 32'h8080_0000) && (a <= 32'h80BF_FFFF);
  endfunction

  // Behavioural reference: 0 idle, 1 request offered, 2 waiting for read data.
  int          m_ph = 0;
  logic [31:0] m_addr;
  int          m_size;
  logic        m_we;
  logic [31:0] m_wdata;

  always @(posedge clk) begin
    if (!rst_n) m_ph <= 0;
    else case (m_ph)
      0: if (cpu_valid && ref_inwin(cpu_addr)) begin
           m_ph <= 1; m_addr <= cpu_addr; m_size <= int'(cpu_size);
           m_we <= cpu_write; m_wdata <= cpu_wdata;
         end
      1: if (cfg_ready) m_ph <= m_we ? 0 : 2;
      default: if (cfg_rvalid) m_ph <= 0;
    endcase
  end

  // Configuration-side responder with pseudo-random stalls and stray strobes.
  logic [15:0] lf = 16'hACE1;
  bit rd_pend = 0;
  always @(posedge clk) begin
    if (!rst_n) rd_pend <= 0;
    else if (cfg_valid && cfg_ready && !cfg_write) rd_pend <= 1;
    else if (cfg_rvalid) rd_pend <= 0;
  end
  always @(negedge clk) begin
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    cfg_ready  = lf[0] | lf[3];
    cfg_rvalid = rd_pend ? lf[5] : (lf[7] & lf[9] & lf[2]);
    cfg_rdata  = {lf[7:0], lf[15:8], ~lf};
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(cpu_ready == (m_ph == 0), "R9 cpu_ready", 32'(cpu_ready), 32'(m_ph == 0));
      chk(cfg_valid == (m_ph == 1), "R1 R9 R11 cfg_valid", 32'(cfg_valid), 32'(m_ph == 1));
      chk(cpu_rvalid == (m_ph == 2 && cfg_rvalid), "R11 cpu_rvalid",
          32'(cpu_rvalid), 32'(m_ph == 2 && cfg_rvalid));
      if (m_ph == 1) begin
        chk(cfg_addr[10:0] == m_addr[10:0], "R2 low bits", 32'(cfg_addr[10:0]), 32'(m_addr[10:0]));
        if (ref_dev(m_addr) == 11)
          chk(int'(cfg_addr[14:11]) == 11, "R4 no select", 32'(cfg_addr[14:11]), 32'd11);
        else
          chk(int'(cfg_addr[14:11]) == ref_dev(m_addr), "R3 device",
              32'(cfg_addr[14:11]), 32'(ref_dev(m_addr)));
        chk(int'(cfg_size) == m_size && cfg_write == m_we, "R8 size/dir",
            {28'(cfg_size), 3'd0, cfg_write}, {28'(m_size), 3'd0, m_we});
        if (m_we)
          chk(cfg_wdata == ref_order(m_wdata, m_size),
              m_size == 4 ? "R6 wdata" : (m_size == 2 ? "R5 wdata" : "R7 wdata"),
              cfg_wdata, ref_order(m_wdata, m_size));
      end
      if (m_ph == 2 && cfg_rvalid)
        chk(cpu_rdata == ref_order(cfg_rdata, m_size),
            m_size == 4 ? "R6 rdata" : (m_size == 2 ? "R5 rdata" : "R7 rdata"),
            cpu_rdata, ref_order(cfg_rdata, m_size));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", cyc, 0);
      finish_run();
    end
  end

  task automatic cpu_do(input logic [31:0] a, input int sz, input bit we, input logic [31:0] d);
    bit ok;
    cpu_valid = 1; cpu_addr = a; cpu_size = 3'(sz); cpu_write = we; cpu_wdata = d;
    forever begin
      #1 ok = cpu_ready;
      @(negedge clk);
      if (ok) break;
    end
    cpu_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(cpu_ready && !cfg_valid && !cpu_rvalid, "R10 reset state",
        {29'd0, cpu_ready, cfg_valid, cpu_rvalid}, 32'h4);
    @(negedge clk);
    // Directed patterns: device select positions, sizes, directions.
    cpu_do(32'h8080_0000 | (32'd1 << 11) | 32'h123, 1, 1, 32'hAABB_CCDD);   // R3 R7
    cpu_do(32'h8080_0000 | (32'd1 << 15) | (32'd1 << 18) | 32'h7FC, 2, 1, 32'h1122_3344); // R3 R5
    cpu_do(32'h8080_0000 | (32'd1 << 21) | 32'h004, 4, 1, 32'h0102_0304);   // R3 R6
    cpu_do(32'h8080_0000 | 32'h3A8, 4, 1, 32'hDEAD_BEEF);                   // R4
    cpu_do(32'h80BF_FFFF, 1, 0, 32'h0);                                     // R3 read
    cpu_do(32'h8080_0000 | (32'd1 << 20) | 32'h010, 2, 0, 32'h0);           // R5 read
    cpu_do(32'h8080_0000 | (32'd1 << 13) | 32'h020, 4, 0, 32'h0);           // R6 read
    // Outside the window: accepted and dropped (R1).
    cpu_do(32'h807F_FFFC, 4, 1, 32'h5555_AAAA);
    cpu_do(32'h80C0_0000, 2, 0, 32'h0);
    cpu_do(32'h0000_0CF8, 4, 0, 32'h0);
    repeat (2) @(negedge clk);
    chk(cpu_ready && !cfg_valid, "R1 after drops", {30'd0, cpu_ready, cfg_valid}, 32'h2);
    // Mixed random traffic.
    for (int n = 0; n < 300; n++) begin
      int sz;
      logic [31:0] a;
      sz = (n % 3 == 0) ? 1 : ((n % 3 == 1) ? 2 : 4);
      a  = 32'h8080_0000 | ($urandom & 32'h003F_FFFF);
      if ((n % 5) == 1) a = (a & 32'hFFC0_07FF) | (32'd1 << (11 + ($urandom % 11)));
      if ((n % 7) == 3) a = a & 32'hFFC0_07FF;
      if ((n % 11) == 5) a = $urandom;
      cpu_do(a, sz, ($urandom % 2) == 1, $urandom);
    end
    repeat (40) @(negedge clk);
    finish_run();
  end
endmodule